// File: doc/BRIEF.md
# Three-Bank Cascaded Interrupt Controller

The block gathers up to 94 external interrupt lines into a single interrupt request for a processor. It is built from three identical 32-source banks. One bank is primary. Two are secondary, and each secondary's registered request drives one dedicated input of the primary bank. Every source has its own polarity setting and its own choice between level and edge sensitivity. Edge events are latched in a pending register and stay there until software clears them by writing ones. Sources on the external pins pass through a two-flop synchronizer. The two cascade inputs are already in the clock domain, so they skip it.

Software programs the block over a plain register bus with address, write data, write enable, read enable and read data. The upper two address bits select a bank. The lower three bits select a register inside that bank: enable, polarity, kind, pending and active. The processor sees only the primary bank's request on `irq_o`. When that request is high, software reads the primary active register. If a cascade bit is set there, it goes on to the secondary bank named by that bit.

Top module: `irq_cascade`

## Requirements
- R1: After reset, every bank's enable, polarity and kind registers read 0, every edge latch is clear, and `irq_o` is 0.
- R2: For a source whose kind bit is 0 (level), its pending bit equals 1 when the synchronized input equals its polarity bit (polarity 1 means active-high, 0 means active-low), and 0 otherwise. The pending bit follows the input three clocks after the input changes.
- R3: For a source whose kind bit is 1 (edge), its pending bit is set by a rising input edge when the polarity bit is 1, or by a falling edge when it is 0. The opposite edge does not set it. Once set, the bit holds after the input returns.
- R4: Writing the pending register (offset 3) clears each edge-kind bit that is written as 1. Bits written as 0 are unchanged. Level-kind bits are not affected by the write.
- R5: If a selected edge is detected in the same cycle as a write that clears that bit, the bit stays set.
- R6: The active register (offset 4) reads pending AND enable, bit by bit. A source whose enable bit is 0 never appears there. Writes to offset 4 have no effect.
- R7: `irq_o` is a register that holds the OR of the primary active bits. It changes one clock after the enable or pending state changes.
- R8: Primary source 0 is driven by the request of secondary bank A (bank 1). Primary source 1 is driven by the request of secondary bank B (bank 2). Primary sources 2 to 31 come from `pri_src_i[29:0]`, and secondary sources n come from bit n of their own input.
- R9: Address bits [4:3] select the bank: 0 is primary, 1 is secondary A, 2 is secondary B. Bits [2:0] select the register: 0 enable, 1 polarity, 2 kind, 3 pending, 4 active. Bank 3, and register offsets 5 to 7, read as 0 and ignore writes. Enable, polarity and kind read back the last value written.
- R10: Read data is registered. It shows the addressed register one clock after `bus_re_i` is high, and it is 0 in the clock after a cycle with `bus_re_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_src_i | input | 30 | External sources 2..31 of the primary bank |
| sec_a_src_i | input | 32 | Sources of secondary bank A |
| sec_b_src_i | input | 32 | Sources of secondary bank B |
| bus_addr_i | input | 5 | Bank select [4:3], register offset [2:0] |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong pending or enable bit shows on `irq_o` one clock later in the primary bank. It takes three clocks in a secondary bank, through the cascade input. A wrong bit is also visible in any read of the pending or active register. The bench runs a behavioural model of all three banks and compares `irq_o` and the read data on every clock, so a divergence is reported in the cycle it first reaches a port. Directed sequences place edges against clear writes, change polarity and kind while inputs are held, and chain secondary requests through the primary, to reach the corner cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned SRC_W       = 32;
    localparam int unsigned NUM_BANKS   = 3;
    localparam int unsigned BANK_W      = 2;
    localparam int unsigned OFF_W       = 3;
    localparam int unsigned ADDR_W      = BANK_W + OFF_W;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned NUM_CASC    = NUM_BANKS - 1;
    localparam int unsigned PRI_EXT_W   = SRC_W - NUM_CASC;
    // Cascade inputs occupy the lowest primary bits, one per secondary bank.
    localparam logic [SRC_W-1:0] CASC_MASK = SRC_W'((1 << NUM_CASC) - 1);

    typedef enum logic [OFF_W-1:0] {
        REG_ENABLE = 3'd0,
        REG_POLAR  = 3'd1,
        REG_KIND   = 3'd2,
        REG_PEND   = 3'd3,
        REG_ACTIVE = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] enable;
        logic [SRC_W-1:0] polar;
        logic [SRC_W-1:0] kind;
        logic [SRC_W-1:0] pend;
        logic [SRC_W-1:0] last;
        logic             irq;
    } bank_state_t;

    typedef struct packed {
        logic [SRC_W-1:0] rdata;
    } port_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned        WIDTH  = 32,
    parameter int unsigned        STAGES = 2,
    parameter logic [WIDTH-1:0]   BYPASS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (BYPASS[b]) begin : g_pass
            // Already synchronous to clk: no added latency.
            assign sync_o[b] = async_i[b];
        end else begin : g_sync
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                end
            end
            assign sync_o[b] = chain_q[STAGES-1];
        end
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_pkg::*;
#(
    parameter logic [SRC_W-1:0] BYPASS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] rdata_o,
    output logic             irq_o
);
    logic [SRC_W-1:0] sync_w;

    irq_sync #(
        .WIDTH (SRC_W),
        .STAGES(SYNC_STAGES),
        .BYPASS(BYPASS)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(src_i),
        .sync_o (sync_w)
    );

    bank_state_t      st_d, st_q;
    logic [SRC_W-1:0] rise_w, fall_w, edge_w, level_w, clr_w, active_w;
    reg_sel_e         sel_w;

    always_comb begin
        sel_w    = reg_sel_e'(off_i);
        rise_w   = sync_w & ~st_q.last;
        fall_w   = ~sync_w & st_q.last;
        edge_w   = (st_q.polar & rise_w) | (~st_q.polar & fall_w);
        level_w  = ~(sync_w ^ st_q.polar);
        active_w = st_q.pend & st_q.enable;
        clr_w    = (wr_en_i && sel_w == REG_PEND) ? wdata_i : '0;

        st_d      = st_q;
        st_d.last = sync_w;
        // Edge bits: clear first, then a fresh edge sets; level bits track.
        st_d.pend = (st_q.kind & ((st_q.pend & ~clr_w) | edge_w))
                  | (~st_q.kind & level_w);
        st_d.irq  = |active_w;

        if (wr_en_i) begin
            case (sel_w)
                REG_ENABLE: st_d.enable = wdata_i;
                REG_POLAR:  st_d.polar  = wdata_i;
                REG_KIND:   st_d.kind   = wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel_w)
            REG_ENABLE: rdata_o = st_q.enable;
            REG_POLAR:  rdata_o = st_q.polar;
            REG_KIND:   rdata_o = st_q.kind;
            REG_PEND:   rdata_o = st_q.pend;
            REG_ACTIVE: rdata_o = active_w;
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PRI_EXT_W-1:0] pri_src_i,
    input  logic [SRC_W-1:0]     sec_a_src_i,
    input  logic [SRC_W-1:0]     sec_b_src_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [SRC_W-1:0]     bus_wdata_i,
    input  logic                 bus_we_i,
    input  logic                 bus_re_i,
    output logic [SRC_W-1:0]     bus_rdata_o,
    output logic                 irq_o
);
    logic [BANK_W-1:0]    bank_w;
    logic [OFF_W-1:0]     off_w;
    logic [SRC_W-1:0]     bank_src [NUM_BANKS];
    logic [SRC_W-1:0]     bank_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    assign bank_w = bus_addr_i[ADDR_W-1 -: BANK_W];
    assign off_w  = bus_addr_i[OFF_W-1:0];

    // Primary bit k-1 carries the request of secondary bank k.
    assign bank_src[0] = {pri_src_i, bank_irq[NUM_BANKS-1:1]};
    assign bank_src[1] = sec_a_src_i;
    assign bank_src[2] = sec_b_src_i;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [SRC_W-1:0] BYP = (g == 0) ? CASC_MASK : '0;
        irq_bank #(
            .BYPASS(BYP)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (bank_src[g]),
            .wr_en_i(bus_we_i && (bank_w == BANK_W'(g))),
            .off_i  (off_w),
            .wdata_i(bus_wdata_i),
            .rdata_o(bank_rd[g]),
            .irq_o  (bank_irq[g])
        );
    end

    port_state_t port_d, port_q;

    always_comb begin
        port_d       = port_q;
        port_d.rdata = '0;
        if (bus_re_i) begin
            for (int g = 0; g < NUM_BANKS; g++) begin
                if (bank_w == BANK_W'(g)) begin
                    port_d.rdata = bank_rd[g];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign bus_rdata_o = port_q.rdata;
    assign irq_o       = bank_irq[0];
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [SRC_W-1:0]  bus_wdata_i,
    input logic              bus_we_i,
    input logic              bus_re_i,
    input logic [SRC_W-1:0]  bus_rdata_o
);
    logic             armed_q;
    logic [SRC_W-1:0] en_shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            en_shadow_q <= '0;
        end else begin
            armed_q <= 1'b1;
            if (bus_we_i && bus_addr_i == ADDR_W'(0)) begin
                en_shadow_q <= bus_wdata_i;
            end
        end
    end

    // R10
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(bus_re_i) |-> bus_rdata_o == '0);

    // R9
    rd_hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(bus_re_i && (bus_addr_i[ADDR_W-1 -: BANK_W] == 2'b11
                           || bus_addr_i[OFF_W-1:0] > 3'd4)) |-> bus_rdata_o == '0);

    // R9
    rd_enable_back_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(bus_re_i && bus_addr_i == ADDR_W'(0)) |-> bus_rdata_o == $past(en_shadow_q));

    // R6
    rd_active_gated_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(bus_re_i && bus_addr_i == ADDR_W'(4)) |-> (bus_rdata_o & ~$past(en_shadow_q)) == '0);
endmodule

bind irq_cascade irq_cascade_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_we_i   (bus_we_i),
    .bus_re_i   (bus_re_i),
    .bus_rdata_o(bus_rdata_o)
);

// File: tb/irq_cascade_tb.sv
`timescale 1ns/1ps
module irq_cascade_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] pri_src = '0;
    logic [31:0] sec_a = '0;
    logic [31:0] sec_b = '0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_cascade u_dut (
        .clk(clk), .rst_n(rst_n), .pri_src_i(pri_src), .sec_a_src_i(sec_a),
        .sec_b_src_i(sec_b), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // Behavioural reference of all three banks.
    logic [31:0] m_s1 [3], m_s2 [3], m_last [3], m_pend [3];
    logic [31:0] m_en [3], m_pol [3], m_kind [3];
    logic [2:0]  m_irq;
    logic [31:0] m_rd;

    function automatic logic [31:0] ext_in(int b);
        if (b == 0) return {pri_src, 2'b00};
        if (b == 1) return sec_a;
        return sec_b;
    endfunction

    function automatic logic [31:0] eff(int b);
        if (b == 0) return {m_s2[0][31:2], m_irq[2], m_irq[1]};
        return m_s2[b];
    endfunction

    function automatic logic [31:0] next_pend(int b);
        logic [31:0] e, hit, clr;
        e   = eff(b);
        hit = (m_pol[b] & e & ~m_last[b]) | (~m_pol[b] & ~e & m_last[b]);
        clr = (we && addr == {b[1:0], 3'd3}) ? wdata : 32'h0;
        return (m_kind[b] & ((m_pend[b] & ~clr) | hit)) | (~m_kind[b] & ~(e ^ m_pol[b]));
    endfunction

    function automatic logic [31:0] read_val(logic [4:0] a);
        int b;
        b = int'(a[4:3]);
        if (b > 2) return 32'h0;
        case (a[2:0])
            3'd0: return m_en[b];
            3'd1: return m_pol[b];
            3'd2: return m_kind[b];
            3'd3: return m_pend[b];
            3'd4: return m_pend[b] & m_en[b];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            for (int b = 0; b < 3; b++) begin
                m_s1[b] <= '0; m_s2[b] <= '0; m_last[b] <= '0; m_pend[b] <= '0;
                m_en[b] <= '0; m_pol[b] <= '0; m_kind[b] <= '0;
            end
            m_irq <= '0;
            m_rd  <= '0;
        end else begin
            for (int b = 0; b < 3; b++) begin
                m_s1[b]   <= ext_in(b);
                m_s2[b]   <= m_s1[b];
                m_last[b] <= eff(b);
                m_pend[b] <= next_pend(b);
                m_irq[b]  <= |(m_pend[b] & m_en[b]);
                if (we && int'(addr[4:3]) == b) begin
                    case (addr[2:0])
                        3'd0: m_en[b]   <= wdata;
                        3'd1: m_pol[b]  <= wdata;
                        3'd2: m_kind[b] <= wdata;
                        default: ;
                    endcase
                end
            end
            m_rd <= re ? read_val(addr) : 32'h0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 irq_o against model", {31'h0, irq}, {31'h0, m_irq[0]});
            check("R10 read data against model", rdata, m_rd);
        end
    end

    task automatic bus_write(input logic [1:0] bank, input logic [2:0] off, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = {bank, off}; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] bank, input logic [2:0] off, output logic [31:0] d);
        @(negedge clk);
        re = 1'b1; addr = {bank, off};
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 irq_o after reset", {31'h0, irq}, 32'h0);
        bus_read(2'd0, 3'd0, v); check("R1 enable reset", v, 32'h0);
        bus_read(2'd1, 3'd1, v); check("R1 polarity reset", v, 32'h0);
        bus_read(2'd2, 3'd2, v); check("R1 kind reset", v, 32'h0);

        // R9 addressing and readback
        bus_write(2'd1, 3'd0, 32'hA5A5_0000);
        bus_read(2'd1, 3'd0, v); check("R9 enable readback bank1", v, 32'hA5A5_0000);
        bus_read(2'd0, 3'd0, v); check("R9 other bank untouched", v, 32'h0);
        bus_write(2'd3, 3'd0, 32'hFFFF_FFFF);
        bus_read(2'd3, 3'd0, v); check("R9 bank3 reads zero", v, 32'h0);
        bus_read(2'd0, 3'd6, v); check("R9 hole offset reads zero", v, 32'h0);
        bus_write(2'd0, 3'd4, 32'hFFFF_FFFF);
        bus_read(2'd0, 3'd4, v); check("R6 active write ignored", v, 32'h0);
        bus_write(2'd1, 3'd0, 32'h0);
        idle(1);
        check("R10 idle read data zero", rdata, 32'h0);

        // R2 level, active-high on bank1 bit4
        bus_write(2'd1, 3'd1, 32'h10);
        sec_a[4] = 1'b1;
        idle(6);
        bus_read(2'd1, 3'd3, v); check("R2 level high asserted", v, 32'hFFFF_FFFF);
        sec_a[4] = 1'b0;
        idle(6);
        bus_read(2'd1, 3'd3, v); check("R2 level high released", v, 32'hFFFF_FFEF);

        // R3/R4 edge, rising on bank2 bit3
        bus_write(2'd2, 3'd2, 32'h8);
        bus_write(2'd2, 3'd1, 32'h8);
        bus_write(2'd2, 3'd3, 32'h8);
        idle(2);
        bus_read(2'd2, 3'd3, v); check("R4 edge bit cleared", v & 32'h8, 32'h0);
        sec_b[3] = 1'b1;
        idle(6);
        bus_read(2'd2, 3'd3, v); check("R3 rising edge latched", v & 32'h8, 32'h8);
        bus_write(2'd2, 3'd3, 32'h0);
        bus_read(2'd2, 3'd3, v); check("R4 write zero keeps bit", v & 32'h8, 32'h8);
        bus_write(2'd2, 3'd3, 32'h28);
        bus_read(2'd2, 3'd3, v); check("R4 clear edge, level bit kept", v & 32'h28, 32'h20);
        sec_b[3] = 1'b0;
        idle(6);
        bus_read(2'd2, 3'd3, v); check("R3 falling edge ignored", v & 32'h8, 32'h0);
        sec_b[3] = 1'b1;
        idle(6);
        sec_b[3] = 1'b0;
        idle(6);
        bus_read(2'd2, 3'd3, v); check("R3 latched after input returns", v & 32'h8, 32'h8);

        // R5 edge beats clear in the same cycle
        @(negedge clk); sec_b[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        we = 1'b1; addr = {2'd2, 3'd3}; wdata = 32'h8;
        @(negedge clk); we = 1'b0;
        bus_read(2'd2, 3'd3, v); check("R5 edge wins over clear", v & 32'h8, 32'h8);
        sec_b[3] = 1'b0;
        idle(4);

        // R8 cascade A into primary bit0, R6 masking, R7 latency
        bus_write(2'd1, 3'd0, 32'h10);
        sec_a[4] = 1'b1;
        bus_write(2'd0, 3'd1, 32'h3);
        bus_write(2'd0, 3'd0, 32'h1);
        idle(10);
        check("R8 cascade A raises irq_o", {31'h0, irq}, 32'h1);
        bus_read(2'd0, 3'd3, v); check("R8 primary pending", v, 32'hFFFF_FFFD);
        bus_read(2'd0, 3'd4, v); check("R6 active only enabled", v, 32'h1);
        bus_write(2'd0, 3'd0, 32'h0);
        check("R7 irq_o holds one clock", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R7 irq_o drops next clock", {31'h0, irq}, 32'h0);
        bus_read(2'd0, 3'd4, v); check("R6 disabled not active", v, 32'h0);

        // R8 cascade B into primary bit1
        bus_write(2'd0, 3'd0, 32'h2);
        bus_write(2'd2, 3'd0, 32'h20);
        idle(10);
        check("R8 cascade B raises irq_o", {31'h0, irq}, 32'h1);
        bus_write(2'd2, 3'd0, 32'h0);
        idle(10);
        check("R8 cascade B released", {31'h0, irq}, 32'h0);

        // R2 active-low primary external source
        bus_write(2'd0, 3'd0, 32'h4);
        idle(3);
        check("R2 active-low primary source", {31'h0, irq}, 32'h1);
        pri_src[0] = 1'b1;
        idle(8);
        check("R2 active-low released", {31'h0, irq}, 32'h0);

        idle(4);
        finish_run();
    end
endmodule